// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table that lives in memory. A base input holds the physical start of the current process's page directory. The top ten address bits select a directory entry. That entry names the frame that holds a page table, and the next ten bits select an entry in that table. The final entry supplies the frame number. The 12-bit page offset is appended to that frame number to form the physical address.

Each entry fetched is checked before the walk goes on. An entry whose state field says the page is unused gives a protection violation. An entry that is not present gives a page fault. A write to a page whose final entry is read-only is refused. A permitted write to a clean page comes back with a request to set the modified bit of that page table entry, together with the entry's address. The walker takes one translation at a time. It issues at most one memory read at a time, waits for the data each time, and holds `busy` high until it has given its one-cycle response.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `rspValid` and `memReqValid` are low.
- R2: The directory entry is read at `dirBase + vaddr[31:22]*4`. The page table entry is read at `{directory entry bits 31:12, 12'h000} + vaddr[21:12]*4`.
- R3: On success, `rspPaddr` is the page table entry's bits 31:12 with `vaddr[11:0]` appended, and no addition takes place.
- R4: An entry is laid out as follows: bit 0 present, bit 1 writable, bit 2 modified, bits 4:3 state (2'b00 unused, any other value in use), and bits 31:12 frame.
- R5: An entry at either level whose state is 2'b00 ends the walk with cause 2 (unused). This check comes before the present check.
- R6: An in-use entry at either level whose present bit is clear ends the walk with cause 1 (not present).
- R7: A write whose page table entry has the writable bit clear ends with cause 3 (read-only). The writable bit of the directory entry has no effect.
- R8: `rspFault` is 1 exactly when `rspCause` is nonzero (cause 0 means success). On a fault, `rspPaddr` is zero.
- R9: `rspSetDirty` is 1 only for a successful write whose page table entry has the modified bit clear. In that case `rspPteAddr` gives that entry's address. Otherwise both are zero.
- R10: A fault at the directory level ends the walk after one memory read. Any walk that reaches the page table makes exactly two reads. `memReqValid` is never high for two cycles in a row.
- R11: `busy` is high from the cycle after a request is accepted until the response cycle, inclusive. A `reqValid` seen while `busy` is high is ignored.
- R12: `rspValid` is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirBase | input | 32 | Physical address of the current page directory |
| reqValid | input | 1 | Translation request, accepted when `busy` is low |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | Access is a write |
| busy | output | 1 | Translation in flight |
| rspValid | output | 1 | Response pulse |
| rspFault | output | 1 | Translation failed |
| rspCause | output | 2 | 0 ok, 1 not present, 2 unused, 3 read-only |
| rspPaddr | output | 32 | Physical address, zero on fault |
| rspSetDirty | output | 1 | Request to set the modified bit |
| rspPteAddr | output | 32 | Address of the page table entry to mark modified |
| memReqValid | output | 1 | Memory read strobe, one cycle |
| memAddr | output | 32 | Address of the entry to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Entry read from memory |

## Verification
The bench builds the walker with its default index width of 10 and offset width of 12. With these values the last entry of both the directory and a page table (index 1023) can be reached, and an all-ones offset shows that the offset is appended rather than added. A small word array stands in for memory, answers each read one cycle later, and holds two directories and two page tables. Switching `dirBase` between the directories shows that the base really is used as the start address.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int ENTRY_W = 32;

  localparam int BIT_PRESENT  = 0;
  localparam int BIT_WRITABLE = 1;
  localparam int BIT_MODIFIED = 2;
  localparam int STATE_LO     = 3;
  localparam logic [1:0] STATE_UNUSED = 2'b00;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_ABSENT = 2'd1,
    CAUSE_UNUSED = 2'd2,
    CAUSE_RDONLY = 2'd3
  } cause_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capReq;
    logic capDir;
    logic capTbl;
    logic tblLevel;
  } ptwStrobe_t;

  // fault classification of one fetched entry
  function automatic cause_e judgeEntry(input logic [ENTRY_W-1:0] entry,
                                        input logic isTbl,
                                        input logic isWrite);
    if (entry[STATE_LO+1:STATE_LO] == STATE_UNUSED) return CAUSE_UNUSED;
    if (!entry[BIT_PRESENT]) return CAUSE_ABSENT;
    if (isTbl && isWrite && !entry[BIT_WRITABLE]) return CAUSE_RDONLY;
    return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       memRspValid,
  input  logic       entryFault,
  output ptwStrobe_t strobe,
  output logic       memReqValid,
  output logic       busy,
  output logic       rspValid
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_DIR, ST_WT_DIR, ST_RD_TBL, ST_WT_TBL, ST_DONE
  } walkState_e;

  walkState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD      = stateQ;
    strobe      = '0;
    memReqValid = 1'b0;
    rspValid    = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        strobe.capReq = reqValid;
        if (reqValid) stateD = ST_RD_DIR;
      end
      ST_RD_DIR: begin
        memReqValid = 1'b1;
        stateD      = ST_WT_DIR;
      end
      ST_WT_DIR: begin
        if (memRspValid) begin
          strobe.capDir = 1'b1;
          stateD        = entryFault ? ST_DONE : ST_RD_TBL;
        end
      end
      ST_RD_TBL: begin
        strobe.tblLevel = 1'b1;
        memReqValid     = 1'b1;
        stateD          = ST_WT_TBL;
      end
      ST_WT_TBL: begin
        strobe.tblLevel = 1'b1;
        if (memRspValid) begin
          strobe.capTbl = 1'b1;
          stateD        = ST_DONE;
        end
      end
      ST_DONE: begin
        rspValid = 1'b1;
        stateD   = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign busy = (stateQ != ST_IDLE);

  p_single_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_accept_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid) |=> busy);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !busy);

endmodule

// File: rtl/ptw_dp.sv
module ptw_dp
  import ptw_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  ptwStrobe_t         strobe,
  input  logic [ENTRY_W-1:0] dirBase,
  input  logic [ENTRY_W-1:0] reqVaddr,
  input  logic               reqWrite,
  input  logic [ENTRY_W-1:0] memRspData,
  output logic [ENTRY_W-1:0] memAddr,
  output logic               entryFault,
  output logic               rspFault,
  output logic [1:0]         rspCause,
  output logic [ENTRY_W-1:0] rspPaddr,
  output logic               rspSetDirty,
  output logic [ENTRY_W-1:0] rspPteAddr
);

  localparam int VA_W    = 2 * IDX_W + OFF_W;
  localparam int FRAME_W = ENTRY_W - OFF_W;
  localparam int PAD_W   = ENTRY_W - IDX_W - 2;

  logic [VA_W-1:0]    vaddrQ;
  logic               writeQ;
  logic [FRAME_W-1:0] tblBaseQ;
  logic [FRAME_W-1:0] frameQ;
  logic [OFF_W-1:0]   offQ;
  cause_e             causeQ;
  logic               dirtyQ;
  logic [ENTRY_W-1:0] pteAddrQ;

  logic [IDX_W-1:0]   dirIdx, tblIdx;
  logic [ENTRY_W-1:0] dirAddr, tblAddr;
  cause_e             entryCause;
  logic               needDirty;

  assign dirIdx  = vaddrQ[VA_W-1 -: IDX_W];
  assign tblIdx  = vaddrQ[OFF_W+IDX_W-1 -: IDX_W];
  assign dirAddr = dirBase + {{PAD_W{1'b0}}, dirIdx, 2'b00};
  assign tblAddr = {tblBaseQ, {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, tblIdx, 2'b00};
  assign memAddr = strobe.tblLevel ? tblAddr : dirAddr;

  assign entryCause = judgeEntry(memRspData, strobe.tblLevel, writeQ);
  assign entryFault = (entryCause != CAUSE_NONE);
  assign needDirty  = writeQ && !memRspData[BIT_MODIFIED];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ   <= '0;
      writeQ   <= 1'b0;
      tblBaseQ <= '0;
      frameQ   <= '0;
      offQ     <= '0;
      causeQ   <= CAUSE_NONE;
      dirtyQ   <= 1'b0;
      pteAddrQ <= '0;
    end else if (strobe.capReq) begin
      vaddrQ   <= reqVaddr[VA_W-1:0];
      writeQ   <= reqWrite;
      frameQ   <= '0;
      offQ     <= '0;
      causeQ   <= CAUSE_NONE;
      dirtyQ   <= 1'b0;
      pteAddrQ <= '0;
    end else if (strobe.capDir) begin
      tblBaseQ <= memRspData[ENTRY_W-1:OFF_W];
      causeQ   <= entryCause;
    end else if (strobe.capTbl) begin
      causeQ <= entryCause;
      if (!entryFault) begin
        frameQ   <= memRspData[ENTRY_W-1:OFF_W];
        offQ     <= vaddrQ[OFF_W-1:0];
        dirtyQ   <= needDirty;
        pteAddrQ <= needDirty ? tblAddr : '0;
      end
    end
  end

  assign rspCause    = causeQ;
  assign rspFault    = (causeQ != CAUSE_NONE);
  assign rspPaddr    = {frameQ, offQ};
  assign rspSetDirty = dirtyQ;
  assign rspPteAddr  = pteAddrQ;

  p_dirty_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    dirtyQ |-> writeQ);

  p_fault_sticks_r10: assert property (@(posedge clk) disable iff (!rstN)
    (causeQ != CAUSE_NONE && !strobe.capReq) |=> causeQ == $past(causeQ));

  p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rstN)
    (causeQ == CAUSE_NONE && frameQ != '0) |-> offQ == vaddrQ[OFF_W-1:0]);

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] dirBase,
  input  logic        reqValid,
  input  logic [31:0] reqVaddr,
  input  logic        reqWrite,
  output logic        busy,
  output logic        rspValid,
  output logic        rspFault,
  output logic [1:0]  rspCause,
  output logic [31:0] rspPaddr,
  output logic        rspSetDirty,
  output logic [31:0] rspPteAddr,
  output logic        memReqValid,
  output logic [31:0] memAddr,
  input  logic        memRspValid,
  input  logic [31:0] memRspData
);

  ptwStrobe_t strobe;
  logic       entryFault;

  ptw_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memRspValid (memRspValid),
    .entryFault  (entryFault),
    .strobe      (strobe),
    .memReqValid (memReqValid),
    .busy        (busy),
    .rspValid    (rspValid)
  );

  ptw_dp #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .dirBase     (dirBase),
    .reqVaddr    (reqVaddr),
    .reqWrite    (reqWrite),
    .memRspData  (memRspData),
    .memAddr     (memAddr),
    .entryFault  (entryFault),
    .rspFault    (rspFault),
    .rspCause    (rspCause),
    .rspPaddr    (rspPaddr),
    .rspSetDirty (rspSetDirty),
    .rspPteAddr  (rspPteAddr)
  );

  p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> rspPaddr == '0);

  p_dirty_ok_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspSetDirty) |-> !rspFault);

  p_no_read_in_rsp_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !memReqValid);

endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] dirBase = 32'h0000_1000;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        busy, rspValid, rspFault, rspSetDirty, memReqValid;
  logic [1:0]  rspCause;
  logic [31:0] rspPaddr, rspPteAddr, memAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  int total = 0;
  int bad = 0;
  int reads = 0;
  logic [31:0] mem [0:4095];

  always #5 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rstN(rstN), .dirBase(dirBase),
    .reqValid(reqValid), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .busy(busy), .rspValid(rspValid), .rspFault(rspFault), .rspCause(rspCause),
    .rspPaddr(rspPaddr), .rspSetDirty(rspSetDirty), .rspPteAddr(rspPteAddr),
    .memReqValid(memReqValid), .memAddr(memAddr),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    memRspValid <= 1'b0;
    if (memReqValid) begin
      memRspValid <= 1'b1;
      memRspData  <= mem[memAddr[13:2]];
      reads = reads + 1;
    end
  end

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic [1:0]  cause;
    logic [31:0] pa;
    logic        dirty;
    logic [31:0] pte;
    logic [1:0]  nReads;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0040_0123, 1'b0, 2'd0, 32'hABCD_E123, 1'b0, 32'h0,         2'd2},
    '{32'h0040_0123, 1'b1, 2'd0, 32'hABCD_E123, 1'b1, 32'h0000_2000, 2'd2},
    '{32'h0040_5FFF, 1'b0, 2'd0, 32'h1234_5FFF, 1'b0, 32'h0,         2'd2},
    '{32'h0040_5FFF, 1'b1, 2'd3, 32'h0,         1'b0, 32'h0,         2'd2},
    '{32'h0040_7010, 1'b1, 2'd0, 32'h5555_5010, 1'b0, 32'h0,         2'd2},
    '{32'h0040_9000, 1'b0, 2'd1, 32'h0,         1'b0, 32'h0,         2'd2},
    '{32'h0040_A000, 1'b0, 2'd2, 32'h0,         1'b0, 32'h0,         2'd2},
    '{32'h0080_0000, 1'b0, 2'd1, 32'h0,         1'b0, 32'h0,         2'd1},
    '{32'h00C0_0000, 1'b0, 2'd2, 32'h0,         1'b0, 32'h0,         2'd1},
    '{32'h013F_FABC, 1'b1, 2'd0, 32'hFFFF_FABC, 1'b1, 32'h0000_3FFC, 2'd2},
    '{32'hFFC0_B001, 1'b0, 2'd0, 32'h0F0F_0001, 1'b0, 32'h0,         2'd2},
    '{32'h0080_0000, 1'b1, 2'd1, 32'h0,         1'b0, 32'h0,         2'd1}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitRsp();
    int n = 0;
    while (!rspValid && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(rspValid, "R12 response seen", {31'b0, rspValid}, 32'h1);
  endtask

  task automatic runVec(input vec_t v, input int idx);
    @(negedge clk);
    reads = 0;
    reqValid = 1'b1; reqVaddr = v.va; reqWrite = v.wr;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy, $sformatf("R11 busy after accept v%0d", idx), {31'b0, busy}, 32'h1);
    waitRsp();
    chk(rspCause == v.cause, $sformatf("R5/R6/R7 cause v%0d", idx), {30'b0, rspCause}, {30'b0, v.cause});
    chk(rspFault == (v.cause != 2'd0), $sformatf("R8 fault flag v%0d", idx), {31'b0, rspFault}, {31'b0, v.cause != 2'd0});
    chk(rspPaddr == v.pa, $sformatf("R3 R8 paddr v%0d", idx), rspPaddr, v.pa);
    chk(rspSetDirty == v.dirty, $sformatf("R9 dirty v%0d", idx), {31'b0, rspSetDirty}, {31'b0, v.dirty});
    chk(rspPteAddr == v.pte, $sformatf("R2 R9 pte addr v%0d", idx), rspPteAddr, v.pte);
    chk(reads == int'(v.nReads), $sformatf("R10 read count v%0d", idx), reads, {30'b0, v.nReads});
    @(negedge clk);
    chk(!rspValid && !busy, $sformatf("R12 pulse end v%0d", idx), {30'b0, rspValid, busy}, 32'h0);
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    // directory at 0x1000 (entry layout per R4)
    mem[12'h401] = 32'h0000_2011;  // R7: writable clear in directory
    mem[12'h402] = 32'h0000_3010;  // not present
    mem[12'h404] = 32'h0000_3011;
    mem[12'h7FF] = 32'h0000_2011;
    // page table at 0x2000
    mem[12'h800] = 32'hABCD_E013;
    mem[12'h805] = 32'h1234_5011;
    mem[12'h807] = 32'h5555_5017;
    mem[12'h809] = 32'h0000_0010;
    mem[12'h80B] = 32'h0F0F_0009;
    // page table at 0x3000
    mem[12'hFFF] = 32'hFFFF_F013;
    // second directory at 0x0
    mem[12'h000] = 32'h0000_2011;

    repeat (3) @(negedge clk);
    chk(!busy && !rspValid && !memReqValid, "R1 reset outputs",
        {29'b0, busy, rspValid, memReqValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !memReqValid, "R1 idle after reset", {30'b0, busy, memReqValid}, 32'h0);

    for (int i = 0; i < NV; i++) runVec(VECS[i], i);

    // R11: a request held during a walk is ignored
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = 32'h0040_0123; reqWrite = 1'b0;
    @(negedge clk);
    reqVaddr = 32'h0040_5FFF;
    waitRsp();
    reqValid = 1'b0;
    chk(rspPaddr == 32'hABCD_E123, "R11 held request ignored", rspPaddr, 32'hABCD_E123);
    @(negedge clk);
    chk(!busy && !rspValid, "R11 no second walk", {30'b0, busy, rspValid}, 32'h0);

    // R2: switching the directory base
    dirBase = 32'h0;
    runVec('{32'h0000_0456, 1'b0, 2'd0, 32'hABCD_E456, 1'b0, 32'h0, 2'd2}, 100);
    dirBase = 32'h0000_1000;
    runVec('{32'h0000_0456, 1'b0, 2'd2, 32'h0, 1'b0, 32'h0, 2'd1}, 101);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule